// File: doc/BRIEF.md
# CPU Clock Pair Stop Controller

This block decides, for each of several differential CPU clock pairs, whether the pair toggles, sits in a fixed stopped level, is parked in its disabled level, or has its drivers switched off. It takes an active-low power-down input, an active-low CPU-stop input and a small set of control bits. The control bits are held in a local register that is loaded in one cycle through a write strobe. The pair outputs are the gated true and complement clocks together with one output-enable per pair. These feed the analog output stage, which lies outside this block.

Power-down and CPU-stop are asynchronous. They pass through a reset-to-idle synchroniser clocked by the gated clock. Each pair's state register updates only on the falling clock edge, so a pair starts and stops while the clock is low and never emits a shortened high pulse. The block also forms the internal PCI-stop level: the AND of a register bit and an external active-low pin.

Top module: `cpu_clk_stop_ctl`

## Requirements
- R1: While power-down is asserted (pd_n low) and both tri-state mode bits are 0, every pair drives out_t high, out_c low, and out_oe high.
- R2: While power-down is asserted and cfg_pd_tristate is 1, every pair has out_oe low with out_t and out_c low. cfg_pd_tristate does not change how a pair behaves under CPU-stop.
- R3: When cfg_stop_tristate is 1, a pair that CPU-stop halts has out_oe low instead of holding its stopped level. With that bit set, power-down also turns every pair's drivers off, even when cfg_pd_tristate is 0.
- R4: While CPU-stop is asserted (cpustop_n low), a pair whose free-run bit is 1 keeps toggling (out_t follows clk, out_c follows its inverse). A pair whose free-run bit is 0 holds out_t low and out_c high.
- R5: A pair whose enable bit is 0 drives out_t high, out_c low and out_oe high, whether or not CPU-stop is asserted.
- R6: pcistop_n equals the AND of cfg_pci_run and pcistop_pin_n, with no clock delay.
- R7: After reset the free-run bits and both tri-state mode bits are 0, the enable bits are 1 and cfg_pci_run is 1. So, with no further write, every pair runs, CPU-stop halts all pairs low, and power-down parks them.
- R8: Priority is power-down first, then the per-pair disable, then CPU-stop, then normal running.
- R9: A change on pd_n or cpustop_n reaches the pairs after two rising clock edges. It takes effect at the falling edge that follows, so a pair's state never changes while clk is high. With an input change made just after a rising edge, the output is still toggling at the second rising edge and is settled at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock that is gated onto the pairs |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpustop_n | input | 1 | Asynchronous active-low CPU clock stop request |
| pcistop_pin_n | input | 1 | External active-low PCI-stop pin |
| cfg_we | input | 1 | Loads all cfg_* fields into the control register on a rising edge |
| cfg_free_run | input | NPAIR | Per-pair free-run bit, bit i belongs to pair i |
| cfg_pair_en | input | NPAIR | Per-pair enable bit, bit i belongs to pair i |
| cfg_pd_tristate | input | 1 | Power-down turns drivers off when 1 |
| cfg_stop_tristate | input | 1 | Stopped pairs, and all pairs under power-down, turn drivers off when 1 |
| cfg_pci_run | input | 1 | Register half of the PCI-stop AND |
| out_t | output | NPAIR | True clock output per pair |
| out_c | output | NPAIR | Complement clock output per pair |
| out_oe | output | NPAIR | Output driver enable per pair |
| pcistop_n | output | 1 | Combined active-low PCI-stop |

## Verification
A wrong synchroniser stage or a state update on the wrong edge shows up as a pair that halts one cycle early or late, or as a high pulse on out_t shorter than half a period. The bench times both against the third rising edge after the input change. A wrong priority or a lost control bit leaves a pair in the wrong one of four observable classes: toggling, held low, parked high, or drivers off. This appears at the first falling edge after the inputs settle, and the bench classifies each pair by sampling both clock phases. A bad reset value shows on the first stop or power-down request made without a prior write.

// File: rtl/csc_pkg.sv
package csc_pkg;
   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_STOP = 2'd1,
      PS_PARK = 2'd2,
      PS_HIZ  = 2'd3
   } pair_st_e;

   // Ranked decision: power-down, then disable, then CPU-stop, then run.
   function automatic pair_st_e pair_decide(
      input logic pd_act, input logic stop_act, input logic en,
      input logic free, input logic pd_tri, input logic stop_tri);
      pair_st_e r;
      if (pd_act)
         r = (pd_tri || stop_tri) ? PS_HIZ : PS_PARK;
      else if (!en)
         r = PS_PARK;
      else if (stop_act && !free)
         r = stop_tri ? PS_HIZ : PS_STOP;
      else
         r = PS_RUN;
      return r;
   endfunction
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
   parameter int   WIDTH     = 1,
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("csc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{RESET_VAL}};
      end else begin
         chain[0] <= d_async;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/csc_cfg.sv
module csc_cfg #(
   parameter int NPAIR = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [NPAIR-1:0] free_d,
   input  logic [NPAIR-1:0] en_d,
   input  logic             pd_tri_d,
   input  logic             stop_tri_d,
   input  logic             pci_run_d,
   output logic [NPAIR-1:0] free_q,
   output logic [NPAIR-1:0] en_q,
   output logic             pd_tri_q,
   output logic             stop_tri_q,
   output logic             pci_run_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q     <= '0;
         en_q       <= '1;
         pd_tri_q   <= 1'b0;
         stop_tri_q <= 1'b0;
         pci_run_q  <= 1'b1;
      end else if (we) begin
         free_q     <= free_d;
         en_q       <= en_d;
         pd_tri_q   <= pd_tri_d;
         stop_tri_q <= stop_tri_d;
         pci_run_q  <= pci_run_d;
      end
   end
endmodule

// File: rtl/csc_pair.sv
module csc_pair
   import csc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pd_act,
   input  logic     stop_act,
   input  logic     en,
   input  logic     free,
   input  logic     pd_tri,
   input  logic     stop_tri,
   output logic     o_t,
   output logic     o_c,
   output logic     o_oe,
   output pair_st_e st
);
   pair_st_e nxt;

   assign nxt = pair_decide(pd_act, stop_act, en, free, pd_tri, stop_tri);

   // Falling-edge update: the clock is low whenever the pair mode changes.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) st <= PS_RUN;
      else        st <= nxt;
   end

   always_comb begin
      unique case (st)
         PS_RUN:  begin o_t = clk;  o_c = ~clk; o_oe = 1'b1; end
         PS_STOP: begin o_t = 1'b0; o_c = 1'b1; o_oe = 1'b1; end
         PS_PARK: begin o_t = 1'b1; o_c = 1'b0; o_oe = 1'b1; end
         default: begin o_t = 1'b0; o_c = 1'b0; o_oe = 1'b0; end
      endcase
   end
endmodule

// File: rtl/cpu_clk_stop_ctl.sv
module cpu_clk_stop_ctl
   import csc_pkg::*;
#(
   parameter int NPAIR       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_n,
   input  logic             cpustop_n,
   input  logic             pcistop_pin_n,
   input  logic             cfg_we,
   input  logic [NPAIR-1:0] cfg_free_run,
   input  logic [NPAIR-1:0] cfg_pair_en,
   input  logic             cfg_pd_tristate,
   input  logic             cfg_stop_tristate,
   input  logic             cfg_pci_run,
   output logic [NPAIR-1:0] out_t,
   output logic [NPAIR-1:0] out_c,
   output logic [NPAIR-1:0] out_oe,
   output logic             pcistop_n
);
   localparam int ST_W = $bits(pair_st_e);

   generate
      if (NPAIR < 1) begin : g_bad_npair
         $error("cpu_clk_stop_ctl: NPAIR must be at least 1");
      end
   endgenerate

   logic [1:0]        req_n_s;
   logic              pd_act, stop_act;
   logic [NPAIR-1:0]  free_q, en_q;
   logic              pd_tri_q, stop_tri_q, pci_run_q;
   logic [ST_W*NPAIR-1:0] st_flat;

   csc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({pd_n, cpustop_n}),
      .q       (req_n_s)
   );

   assign pd_act   = ~req_n_s[1];
   assign stop_act = ~req_n_s[0];

   csc_cfg #(.NPAIR(NPAIR)) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .free_d     (cfg_free_run),
      .en_d       (cfg_pair_en),
      .pd_tri_d   (cfg_pd_tristate),
      .stop_tri_d (cfg_stop_tristate),
      .pci_run_d  (cfg_pci_run),
      .free_q     (free_q),
      .en_q       (en_q),
      .pd_tri_q   (pd_tri_q),
      .stop_tri_q (stop_tri_q),
      .pci_run_q  (pci_run_q)
   );

   generate
      for (genvar i = 0; i < NPAIR; i++) begin : g_pair
         pair_st_e st_i;
         csc_pair pair_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pd_act   (pd_act),
            .stop_act (stop_act),
            .en       (en_q[i]),
            .free     (free_q[i]),
            .pd_tri   (pd_tri_q),
            .stop_tri (stop_tri_q),
            .o_t      (out_t[i]),
            .o_c      (out_c[i]),
            .o_oe     (out_oe[i]),
            .st       (st_i)
         );
         assign st_flat[i*ST_W +: ST_W] = st_i;
      end
   endgenerate

   assign pcistop_n = pci_run_q & pcistop_pin_n;
endmodule

// File: rtl/csc_chk.sv
module csc_chk
   import csc_pkg::*;
#(
   parameter int NPAIR = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pd_act,
   input logic                 stop_act,
   input logic [NPAIR-1:0]     free_q,
   input logic [NPAIR-1:0]     en_q,
   input logic                 pd_tri_q,
   input logic                 stop_tri_q,
   input logic [2*NPAIR-1:0]   st_flat,
   input logic [NPAIR-1:0]     out_oe
);
   // R9: pair modes move only while the clock is low.
   always @(st_flat) begin
      if (rst_n === 1'b1) begin
         p_edge_low_r9: assert (clk == 1'b0)
            else $error("pair state changed while clk high");
      end
   end

   // R2/R3: any tri-state mode during power-down removes every driver.
   p_pd_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_act && (pd_tri_q || stop_tri_q)) |-> (out_oe == '0));

   for (genvar i = 0; i < NPAIR; i++) begin : g_chk
      p_pd_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (pd_act && !pd_tri_q && !stop_tri_q) |->
            (st_flat[2*i +: 2] == PS_PARK && out_oe[i]));
      p_dis_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!pd_act && !en_q[i]) |-> (st_flat[2*i +: 2] == PS_PARK));
      p_free_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!pd_act && en_q[i] && free_q[i]) |-> (st_flat[2*i +: 2] == PS_RUN));
      p_stop_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!pd_act && en_q[i] && stop_act && !free_q[i] && stop_tri_q) |->
            !out_oe[i]);
   end
endmodule

bind cpu_clk_stop_ctl csc_chk #(.NPAIR(NPAIR)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .pd_act     (pd_act),
   .stop_act   (stop_act),
   .free_q     (free_q),
   .en_q       (en_q),
   .pd_tri_q   (pd_tri_q),
   .stop_tri_q (stop_tri_q),
   .st_flat    (st_flat),
   .out_oe     (out_oe)
);

// File: tb/cpu_clk_stop_ctl_tb_top.sv
`timescale 1ns/1ps
module cpu_clk_stop_ctl_tb_top;
   localparam int NP = 3;
   // class codes seen at the pins
   localparam int C_RUN = 0, C_STOP = 1, C_PARK = 2, C_HIZ = 3, C_BAD = 4;

   typedef struct {
      string  tag;
      int     cls [NP];
      logic   pci;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_n = 1'b1, cpustop_n = 1'b1, pcistop_pin_n = 1'b1;
   logic cfg_we = 1'b0;
   logic [NP-1:0] cfg_free_run = '0, cfg_pair_en = '1;
   logic cfg_pd_tristate = 1'b0, cfg_stop_tristate = 1'b0, cfg_pci_run = 1'b1;
   logic [NP-1:0] out_t, out_c, out_oe;
   logic pcistop_n;

   int total = 0, bad = 0, pushed = 0, popped = 0;
   bit  done = 0;
   exp_t q[$];
   realtime rise_t = 0;

   always #2.5 clk = ~clk;

   cpu_clk_stop_ctl #(.NPAIR(NP), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpustop_n(cpustop_n),
      .pcistop_pin_n(pcistop_pin_n), .cfg_we(cfg_we),
      .cfg_free_run(cfg_free_run), .cfg_pair_en(cfg_pair_en),
      .cfg_pd_tristate(cfg_pd_tristate), .cfg_stop_tristate(cfg_stop_tristate),
      .cfg_pci_run(cfg_pci_run), .out_t(out_t), .out_c(out_c),
      .out_oe(out_oe), .pcistop_n(pcistop_n)
   );

   task automatic check(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor: classify every pair over one high and one low phase.
   initial begin
      forever begin
         exp_t e;
         logic [NP-1:0] th, ch, oh, tl, cl, ol;
         logic ph;
         wait (q.size() > 0);
         e = q.pop_front();
         @(posedge clk); #1; th = out_t; ch = out_c; oh = out_oe; ph = pcistop_n;
         @(negedge clk); #1; tl = out_t; cl = out_c; ol = out_oe;
         for (int i = 0; i < NP; i++) begin
            int c;
            if (!oh[i] && !ol[i] && !th[i] && !tl[i] && !ch[i] && !cl[i]) c = C_HIZ;
            else if (!(oh[i] && ol[i])) c = C_BAD;
            else if (th[i] && !tl[i] && !ch[i] && cl[i]) c = C_RUN;
            else if (!th[i] && !tl[i] && ch[i] && cl[i]) c = C_STOP;
            else if (th[i] && tl[i] && !ch[i] && !cl[i]) c = C_PARK;
            else c = C_BAD;
            check($sformatf("%s pair%0d", e.tag, i), c, e.cls[i]);
         end
         check($sformatf("%s pci", e.tag), int'(ph), int'(e.pci));
         popped++;
      end
   end

   // R9: no shortened high pulse on pair 0 true output
   always @(out_t[0]) begin
      if (rst_n === 1'b1 && done == 0) begin
         if (out_t[0] === 1'b1) rise_t = $realtime;
         else if (out_t[0] === 1'b0 && rise_t > 0) begin
            if ($realtime - rise_t < 2.4) check("R9 runt high pulse", 0, 1);
         end
      end
   end

   task automatic wr_cfg(input logic [NP-1:0] fr, input logic [NP-1:0] en,
                         input logic pdt, input logic stt, input logic pr);
      @(posedge clk); #1;
      cfg_free_run = fr; cfg_pair_en = en; cfg_pd_tristate = pdt;
      cfg_stop_tristate = stt; cfg_pci_run = pr; cfg_we = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic expect_cls(input string tag, input int c2, input int c1,
                             input int c0, input logic pci);
      exp_t e;
      repeat (4) @(posedge clk);
      #1;
      e.tag = tag; e.cls[2] = c2; e.cls[1] = c1; e.cls[0] = c0; e.pci = pci;
      q.push_back(e);
      pushed++;
      wait (popped == pushed);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5.0);
      check("watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R7 reset defaults
      expect_cls("R7 after reset", C_RUN, C_RUN, C_RUN, 1'b1);
      cpustop_n = 1'b0;
      expect_cls("R7 R4 default stop", C_STOP, C_STOP, C_STOP, 1'b1);
      cpustop_n = 1'b1; pd_n = 1'b0;
      expect_cls("R7 R1 default power-down", C_PARK, C_PARK, C_PARK, 1'b1);
      cpustop_n = 1'b0;
      expect_cls("R8 R1 pd over stop", C_PARK, C_PARK, C_PARK, 1'b1);
      pd_n = 1'b1; cpustop_n = 1'b1;

      // R4 per-pair free run
      wr_cfg(3'b101, 3'b111, 1'b0, 1'b0, 1'b1);
      cpustop_n = 1'b0;
      expect_cls("R4 free-run mix", C_RUN, C_STOP, C_RUN, 1'b1);

      // R5 / R8 disable
      wr_cfg(3'b101, 3'b110, 1'b0, 1'b0, 1'b1);
      expect_cls("R8 R5 disable over stop", C_RUN, C_STOP, C_PARK, 1'b1);
      cpustop_n = 1'b1;
      expect_cls("R5 disable no stop", C_RUN, C_RUN, C_PARK, 1'b1);

      // R2 power-down tri-state
      wr_cfg(3'b000, 3'b111, 1'b1, 1'b0, 1'b1);
      pd_n = 1'b0;
      expect_cls("R2 pd tristate", C_HIZ, C_HIZ, C_HIZ, 1'b1);
      pd_n = 1'b1; cpustop_n = 1'b0;
      expect_cls("R2 pd mode ignored by stop", C_STOP, C_STOP, C_STOP, 1'b1);
      cpustop_n = 1'b1;

      // R3 stop tri-state
      wr_cfg(3'b010, 3'b111, 1'b0, 1'b1, 1'b1);
      cpustop_n = 1'b0;
      expect_cls("R3 stop tristate", C_HIZ, C_RUN, C_HIZ, 1'b1);
      cpustop_n = 1'b1; pd_n = 1'b0;
      expect_cls("R3 pd tristate via stop bit", C_HIZ, C_HIZ, C_HIZ, 1'b1);
      pd_n = 1'b1;
      expect_cls("R3 release", C_RUN, C_RUN, C_RUN, 1'b1);

      // R8 pd over disable
      wr_cfg(3'b000, 3'b110, 1'b1, 1'b0, 1'b1);
      pd_n = 1'b0;
      expect_cls("R8 pd over disable", C_HIZ, C_HIZ, C_HIZ, 1'b1);
      pd_n = 1'b1;

      // R6 PCI-stop AND
      wr_cfg(3'b000, 3'b111, 1'b0, 1'b0, 1'b1);
      pcistop_pin_n = 1'b0;
      expect_cls("R6 pin low", C_RUN, C_RUN, C_RUN, 1'b0);
      wr_cfg(3'b000, 3'b111, 1'b0, 1'b0, 1'b0);
      pcistop_pin_n = 1'b1;
      expect_cls("R6 reg low", C_RUN, C_RUN, C_RUN, 1'b0);
      wr_cfg(3'b000, 3'b111, 1'b0, 1'b0, 1'b1);
      expect_cls("R6 both high", C_RUN, C_RUN, C_RUN, 1'b1);

      // R9 latency of stop and restart on pair 0
      @(posedge clk); #1 cpustop_n = 1'b0;
      @(posedge clk);
      @(posedge clk); #1 check("R9 still running at edge 2", int'(out_t[0]), 1);
      @(posedge clk); #1 check("R9 stopped at edge 3", int'(out_t[0]), 0);
      cpustop_n = 1'b1;
      @(posedge clk);
      @(posedge clk); #1 check("R9 still stopped at edge 2", int'(out_t[0]), 0);
      @(posedge clk); #1 check("R9 running at edge 3", int'(out_t[0]), 1);

      repeat (4) @(posedge clk);
      finish_run();
   end
endmodule